// File: doc/BRIEF.md
# Unlock-Protected Memory Mode Register

This block is an 8-bit control register on a special-function-register bus. It sets how program and data memory are arranged. Two of its bits drive live outputs: the external flash program-enable (`pgm_wr_en`) and the memory bank swap (`swap_en`). Software cannot change these bits with a plain write. It has to use a short protected sequence that runs on instruction-cycle ticks.

The first write sets an arm flag and carries the new program-enable and swap values. The write on the very next tick must set the commit bit. The arm flag clears by itself two ticks after it was set. The committed values reach the outputs two ticks after the commit, which leaves time for the core to reload its program counter.

The program-enable bits are also loaded from an external pin when reset or hardware power-down ends. While that pin is low, the active program-enable is forced clear on every tick.

Top module: `memorg_ctl`

## Requirements
- R1: While `rst_n` is low, `pgm_wr_en` and `swap_en` are 0 and the arm flag is 0. At the first clock edge after `rst_n` rises, the program-enable bit and the program-enable status bit both take the level of `prg_pin`.
- R2: A clock edge with `pdn` high clears the arm flag, any pending change, the program-enable bits and swap. At the first clock edge after `pdn` falls, both program-enable bits reload from `prg_pin`.
- R3: When `sfr_addr` equals `REG_ADDR`, `sfr_rdata` presents these fields:

  | Bit | Field |
  |-----|-------|
  | 7 | arm flag |
  | 6 | commit, always read as 0 |
  | 5 | reserved, read as 0 |
  | 4:3 | `amode_stat` |
  | 2 | program-enable |
  | 1 | program-enable status |
  | 0 | swap |

  For any other address, `sfr_rdata` is 0.
- R4: A write to `REG_ADDR` on a tick with bit 7 set arms the sequence, so bit 7 reads 1 after that edge. The same write stages bit 2 as the new program-enable value and bit 0 as the new swap value.
- R5: The arm flag clears by itself at the second tick after the tick that set it.
- R6: A write to `REG_ADDR` with bit 6 set commits the sequence only if it falls on the tick directly after the arming tick. The staged values then appear on `pgm_wr_en` and `swap_en` at the second tick after the commit tick. A commit on any later tick has no effect.
- R7: A write to `REG_ADDR` that is not part of a valid sequence leaves `pgm_wr_en` and `swap_en` unchanged. This includes a commit with no arm before it.
- R8: Any other write on the tick after arming clears the arm flag and aborts the sequence. This covers a write to another address and a write to `REG_ADDR` with bit 6 clear. A commit on the following tick is then ignored.
- R9: On every tick where `prg_pin` is low, `pgm_wr_en` is cleared at that edge, even if a committed 1 is being applied at the same edge.
- R10: Register bits 4:3 and 1 ignore writes. Bits 4:3 always show `amode_stat`.
- R11: On clock edges where `icyc` is low, writes are ignored and neither the sequence state nor the outputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn | input | 1 | Hardware power-down, active high |
| icyc | input | 1 | Instruction-cycle tick; one bus write at most per tick |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | ADDR_W | SFR address for both writes and reads |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Read data for the addressed register |
| prg_pin | input | 1 | External program-enable pin level |
| amode_stat | input | 2 | Address-mode status shown in bits 4:3 |
| pgm_wr_en | output | 1 | Active flash program-enable |
| swap_en | output | 1 | Active memory swap mode |

## Verification
The protected sequence is driven in several forms:
- A correct arm-then-commit pair.
- A commit one tick too late.
- A commit with no arm before it.
- Sequences broken by a write to another address, or by a plain write to the register.

Only the correct pair may change the outputs, and it must change them on the exact tick, so these cases separate a working timing window from one that is too loose or too tight. Sequences repeated with the pin low, and then high, show whether the forced clear takes priority over a commit. Bus writes placed on non-tick clocks between the sequence steps show whether the design counts instruction ticks rather than clocks. Power-down entered and left with a different pin level shows whether the pin is sampled again on release.

// File: rtl/memorg_pkg.sv
package memorg_pkg;
    localparam int REG_W   = 8;
    localparam int B_ARM   = 7;
    localparam int B_CMT   = 6;
    localparam int B_AM_HI = 4;
    localparam int B_AM_LO = 3;
    localparam int B_PE1   = 2;
    localparam int B_PE0   = 1;
    localparam int B_SWP   = 0;
endpackage

// File: rtl/memorg_seq.sv
module memorg_seq #(
    parameter int ARM_LIFE  = 2,
    parameter int ACT_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn,
    input  logic tick,
    input  logic wr_any,
    input  logic wr_reg,
    input  logic wr_arm,
    input  logic wr_cmt,
    output logic arm,
    output logic stage_ld,
    output logic commit_ok,
    output logic apply
);
    localparam int AGW = $clog2(ARM_LIFE + 1);
    localparam int DLW = $clog2(ACT_DELAY + 1);
    localparam logic [AGW-1:0] AGE_LAST = AGW'(ARM_LIFE - 1);
    localparam logic [DLW-1:0] DLY_INIT = DLW'(ACT_DELAY);
    localparam logic [DLW-1:0] DLY_ONE  = DLW'(1);

    typedef struct packed {
        logic           arm;
        logic [AGW-1:0] age;
        logic [DLW-1:0] dly;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d       = s_q;
        stage_ld  = 1'b0;
        commit_ok = 1'b0;
        apply     = 1'b0;
        if (pdn) begin
            s_d = '0;
        end else if (tick) begin
            // countdown to activation
            if (s_q.dly != '0) begin
                s_d.dly = s_q.dly - 1'b1;
                apply   = (s_q.dly == DLY_ONE);
            end
            // arm flag ageing
            if (s_q.arm) begin
                if (s_q.age == AGE_LAST) s_d.arm = 1'b0;
                else                     s_d.age = s_q.age + 1'b1;
            end
            // bus write handling: commit, re-arm, or abort
            if (wr_reg && wr_cmt && s_q.arm && s_q.age == '0) begin
                commit_ok = 1'b1;
                s_d.dly   = DLY_INIT;
            end else if (wr_reg && wr_arm) begin
                stage_ld = 1'b1;
                s_d.arm  = 1'b1;
                s_d.age  = '0;
            end else if (wr_any && s_q.arm) begin
                s_d.arm = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign arm = s_q.arm;

    // R5: arm flag lives for a fixed number of ticks
    a_r5_arm_expires: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.arm && s_q.age == AGE_LAST && !(wr_reg && wr_arm)) |=> !s_q.arm);

    // R11: sequence state frozen between ticks
    a_r11_seq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !pdn) |=> ($stable(s_q.arm) && $stable(s_q.dly)));
endmodule

// File: rtl/memorg_mode.sv
module memorg_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn,
    input  logic tick,
    input  logic pin,
    input  logic stage_ld,
    input  logic commit_ok,
    input  logic apply,
    input  logic new_pe1,
    input  logic new_swp,
    output logic pe1,
    output logic pe0,
    output logic swp
);
    typedef struct packed {
        logic init;
        logic pe1;
        logic pe0;
        logic swp;
        logic st_pe1;
        logic st_swp;
        logic pd_pe1;
        logic pd_swp;
    } mode_t;

    localparam mode_t MODE_RST = '{init: 1'b1, default: 1'b0};

    mode_t m_q, m_d;

    always_comb begin
        m_d = m_q;
        if (pdn) begin
            m_d = MODE_RST;
        end else begin
            if (m_q.init) begin
                m_d.pe1  = pin;
                m_d.pe0  = pin;
                m_d.init = 1'b0;
            end
            if (stage_ld) begin
                m_d.st_pe1 = new_pe1;
                m_d.st_swp = new_swp;
            end
            if (commit_ok) begin
                m_d.pd_pe1 = m_q.st_pe1;
                m_d.pd_swp = m_q.st_swp;
            end
            if (apply) begin
                m_d.pe1 = m_q.pd_pe1;
                m_d.swp = m_q.pd_swp;
            end
            if (tick && !pin) m_d.pe1 = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= MODE_RST;
        else        m_q <= m_d;
    end

    assign pe1 = m_q.pe1;
    assign pe0 = m_q.pe0;
    assign swp = m_q.swp;

    // R1: pin level captured on the first edge after reset release
    a_r1_pin_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.init && !pdn) |=> (m_q.pe0 == $past(pin)));

    // R9: low pin clears program-enable on the tick
    a_r9_pin_forces_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !pin && !pdn) |=> !m_q.pe1);

    // R7: swap only moves when the sequencer releases a change
    a_r7_swap_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn && !apply) |=> $stable(m_q.swp));
endmodule

// File: rtl/memorg_ctl.sv
module memorg_ctl #(
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h9A,
    parameter int               ARM_LIFE  = 2,
    parameter int               ACT_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pdn,
    input  logic              icyc,
    input  logic              sfr_we,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    input  logic              prg_pin,
    input  logic [1:0]        amode_stat,
    output logic              pgm_wr_en,
    output logic              swap_en
);
    import memorg_pkg::*;

    logic hit, wr_reg;
    logic arm, stage_ld, commit_ok, apply;
    logic pe1, pe0, swp;
    logic unused_wbits;

    assign hit          = (sfr_addr == REG_ADDR);
    assign wr_reg       = sfr_we && hit;
    assign unused_wbits = ^{sfr_wdata[5:3], sfr_wdata[B_PE0]};

    memorg_seq #(
        .ARM_LIFE  (ARM_LIFE),
        .ACT_DELAY (ACT_DELAY)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pdn       (pdn),
        .tick      (icyc),
        .wr_any    (sfr_we),
        .wr_reg    (wr_reg),
        .wr_arm    (sfr_wdata[B_ARM]),
        .wr_cmt    (sfr_wdata[B_CMT]),
        .arm       (arm),
        .stage_ld  (stage_ld),
        .commit_ok (commit_ok),
        .apply     (apply)
    );

    memorg_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .pdn       (pdn),
        .tick      (icyc),
        .pin       (prg_pin),
        .stage_ld  (stage_ld),
        .commit_ok (commit_ok),
        .apply     (apply),
        .new_pe1   (sfr_wdata[B_PE1]),
        .new_swp   (sfr_wdata[B_SWP]),
        .pe1       (pe1),
        .pe0       (pe0),
        .swp       (swp)
    );

    always_comb begin
        sfr_rdata = '0;
        if (hit) begin
            sfr_rdata[B_ARM]           = arm;
            sfr_rdata[B_AM_HI:B_AM_LO] = amode_stat;
            sfr_rdata[B_PE1]           = pe1;
            sfr_rdata[B_PE0]           = pe0;
            sfr_rdata[B_SWP]           = swp;
        end
    end

    assign pgm_wr_en = pe1;
    assign swap_en   = swp;

    // R4: an arming write shows up in the arm flag
    a_r4_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (icyc && !pdn && wr_reg && sfr_wdata[B_ARM] && !sfr_wdata[B_CMT]) |=> arm);
endmodule

// File: tb/tb_memorg_ctl.sv
`timescale 1ns/1ps
module tb_memorg_ctl;
    localparam logic [7:0] REG = 8'h9A;
    localparam logic [7:0] OTH = 8'h55;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pdn = 1'b0;
    logic       icyc = 1'b0;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_addr = REG;
    logic [7:0] sfr_wdata = '0;
    logic [7:0] sfr_rdata;
    logic       prg_pin = 1'b1;
    logic [1:0] amode_stat = 2'b10;
    logic       pgm_wr_en, swap_en;

    always #2 clk = ~clk;

    memorg_ctl dut (
        .clk(clk), .rst_n(rst_n), .pdn(pdn), .icyc(icyc), .sfr_we(sfr_we),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .prg_pin(prg_pin), .amode_stat(amode_stat),
        .pgm_wr_en(pgm_wr_en), .swap_en(swap_en)
    );

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       pe;
        logic       sw;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    // bench-level stimulus knobs
    logic       rst_v = 1'b1, pdn_v = 1'b0, pin_v = 1'b1;
    logic [1:0] am_v = 2'b10;

    // reference model state
    int   T = 0, arm_at = -100, cm_at = -100;
    logic m_arm = 0, m_init = 1;
    logic m_pe1 = 0, m_pe0 = 0, m_sw = 0;
    logic st_pe1 = 0, st_sw = 0, pd_pe1 = 0, pd_sw = 0;

    task automatic step(input string tag, input logic tk, input logic we,
                        input logic [7:0] a, input logic [7:0] d);
        exp_t e;
        @(negedge clk);
        rst_n = !rst_v; pdn = pdn_v; prg_pin = pin_v; amode_stat = am_v;
        icyc = tk; sfr_we = we; sfr_addr = a; sfr_wdata = d;
        if (rst_v || pdn_v) begin
            m_arm = 0; cm_at = -100; m_init = 1;
            m_pe1 = 0; m_pe0 = 0; m_sw = 0;
            st_pe1 = 0; st_sw = 0; pd_pe1 = 0; pd_sw = 0;
        end else begin
            if (m_init) begin m_pe1 = pin_v; m_pe0 = pin_v; m_init = 0; end
            if (tk) begin
                T++;
                if (T == cm_at + 2) begin m_pe1 = pd_pe1; m_sw = pd_sw; end
                if (m_arm && (T - arm_at) >= 2) m_arm = 0;
                if (we && a == REG && d[6] && m_arm && T == arm_at + 1) begin
                    cm_at = T; pd_pe1 = st_pe1; pd_sw = st_sw;
                end else if (we && a == REG && d[7]) begin
                    m_arm = 1; arm_at = T; st_pe1 = d[2]; st_sw = d[0];
                end else if (we && m_arm) begin
                    m_arm = 0;
                end
                if (!pin_v) m_pe1 = 0;
            end
        end
        e.tag = tag;
        e.pe  = m_pe1;
        e.sw  = m_sw;
        e.rd  = (a == REG) ? {m_arm, 2'b00, am_v, m_pe1, m_pe0, m_sw} : 8'h00;
        sb.push_back(e);
    endtask

    // monitor: compare one expected item per clock, after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (sfr_rdata !== e.rd || pgm_wr_en !== e.pe || swap_en !== e.sw) begin
                    n_bad++;
                    $display("FAIL %s: actual rd=%h pe=%b sw=%b expected rd=%h pe=%b sw=%b",
                             e.tag, sfr_rdata, pgm_wr_en, swap_en, e.rd, e.pe, e.sw);
                end
            end
        end
    end

    task automatic unlock(input string tag, input logic [7:0] armv);
        step(tag, 1, 1, REG, armv);
        step(tag, 1, 1, REG, 8'h40);
        step(tag, 1, 0, REG, 8'h00);
        step(tag, 1, 0, REG, 8'h00);
        step(tag, 1, 0, REG, 8'h00);
    endtask

    initial begin
        // R1 reset and pin capture
        step("R1", 0, 0, REG, 0);
        step("R1", 1, 1, REG, 8'h85);
        rst_v = 0;
        step("R1", 0, 0, REG, 0);
        step("R1", 1, 0, REG, 0);
        // R7 plain writes have no effect
        step("R7", 1, 1, REG, 8'h01);
        step("R7", 1, 1, REG, 8'h00);
        step("R7", 1, 0, REG, 0);
        // R10 read-only status bits
        step("R10", 1, 1, REG, 8'h1A);
        am_v = 2'b01;
        step("R10", 1, 0, REG, 0);
        // R4/R5/R6/R11 valid sequence with idle clocks between ticks
        step("R4", 1, 1, REG, 8'h81);
        step("R11", 0, 1, REG, 8'h40);
        step("R11", 0, 1, OTH, 8'hFF);
        step("R6", 1, 1, REG, 8'h40);
        step("R5", 1, 0, REG, 0);
        step("R5", 0, 0, REG, 0);
        step("R6", 1, 0, REG, 0);
        step("R6", 1, 0, REG, 0);
        unlock("R6", 8'h84);
        // R6 late commit ignored
        step("R6", 1, 1, REG, 8'h81);
        step("R6", 1, 0, REG, 0);
        step("R6", 1, 1, REG, 8'h40);
        step("R6", 1, 0, REG, 0);
        step("R6", 1, 0, REG, 0);
        step("R6", 1, 0, REG, 0);
        // R8 abort by another address, then by a plain register write
        step("R8", 1, 1, REG, 8'h81);
        step("R8", 1, 1, OTH, 8'hFF);
        step("R8", 1, 1, REG, 8'h40);
        step("R8", 1, 0, REG, 0);
        step("R8", 1, 0, REG, 0);
        step("R8", 1, 1, REG, 8'h81);
        step("R8", 1, 1, REG, 8'h00);
        step("R8", 1, 1, REG, 8'h40);
        step("R8", 1, 0, REG, 0);
        step("R8", 1, 0, REG, 0);
        // R7 commit with no arm
        step("R7", 1, 1, REG, 8'h41);
        step("R7", 1, 0, REG, 0);
        step("R7", 1, 0, REG, 0);
        // R3 read of another address
        step("R3", 0, 0, OTH, 0);
        step("R3", 1, 0, OTH, 0);
        // R9 pin low clears and blocks setting
        pin_v = 0;
        step("R9", 0, 0, REG, 0);
        step("R9", 1, 0, REG, 0);
        unlock("R9", 8'h85);
        pin_v = 1;
        unlock("R9", 8'h84);
        // R2 power-down and pin resample
        pdn_v = 1;
        step("R2", 1, 0, REG, 0);
        step("R2", 1, 1, REG, 8'h81);
        pin_v = 0; pdn_v = 0;
        step("R2", 0, 0, REG, 0);
        step("R2", 1, 0, REG, 0);
        pin_v = 1;
        unlock("R2", 8'h85);
        step("R2", 0, 0, REG, 0);
        @(posedge clk);
        #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule